// File: doc/BRIEF.md
# Traffic Class to Virtual Channel Steering Table

This block decides, for each arriving packet, which virtual channel queue receives it. The packet side presents a 3-bit traffic class together with a valid strobe. One clock later the block returns the chosen channel index and a flag that marks a mapping error. Software controls the choice through two write ports. The first loads one entry of an eight-entry class-to-channel table. The second loads a mask that says which channels exist.

Two rules are enforced in hardware whatever software writes. Class 0 is tied to channel 0, and channel 0 is always enabled. A class whose table entry names a disabled channel is not steered to that channel. It goes to channel 0 instead, and the error flag is raised for that one result. Every write takes effect from the next lookup, so a lookup in the same cycle as a write still sees the old contents.

Top module: `tc_vc_steer`

## Requirements
- R1: After reset `out_vld`, `out_err` and `out_ch` are 0. Every table entry holds channel 0, and only channel 0 is enabled. A lookup of any class therefore returns channel 0 with no error.
- R2: `out_vld` equals `pkt_vld` of the previous cycle. While `out_vld` is 0, `out_ch` and `out_err` are 0.
- R3: A lookup of class c, where entry c names an enabled channel k, returns `out_ch` = k with `out_err` = 0. A write with `map_we` = 1 sets entry `map_idx` to `map_ch`.
- R4: A lookup of class 0 always returns channel 0 with no error. Writes to entry 0 have no effect.
- R5: A lookup of class c, where entry c names a channel whose enable bit is 0, returns `out_ch` = 0 with `out_err` = 1. The flag is high only for that one output cycle.
- R6: A write with `en_we` = 1 loads `en_wdata` into the enable mask. Bit i of the mask enables channel i. Bit 0 is held at 1, so a lookup that resolves to channel 0 never flags an error, even after a write of 0 to bit 0.
- R7: A table write in the same cycle as a lookup does not affect that lookup. It affects the lookups that follow.
- R8: An enable mask write in the same cycle as a lookup does not affect that lookup. It affects the lookups that follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| map_we | input | 1 | Table entry write strobe |
| map_idx | input | CLASS_W | Class whose entry is written |
| map_ch | input | CH_W | Channel stored in that entry |
| en_we | input | 1 | Enable mask write strobe |
| en_wdata | input | NUM_CH | New enable mask, one bit per channel |
| pkt_vld | input | 1 | Packet lookup request |
| pkt_tc | input | CLASS_W | Traffic class of the packet |
| out_vld | output | 1 | Result valid, one cycle after the request |
| out_ch | output | CH_W | Selected channel |
| out_err | output | 1 | Entry named a disabled channel; result forced to 0 |

## Verification
The bound checker tests the following on every cycle:
- the one-cycle valid timing;
- quiet outputs while idle;
- the class 0 lock;
- an error always coming with channel 0;
- a returned channel always being enabled under the mask that was in force at the lookup;
- bit 0 of the mask always being set.

Only the bench scenarios show the rest:
- the channel actually chosen for each programmed entry;
- that writes to entry 0 and to mask bit 0 are ignored;
- the same-cycle ordering of table writes, mask writes and lookups.

The bench checks these against its own model of the table and the mask.

// File: rtl/tcvc_pkg.sv
package tcvc_pkg;
   localparam int unsigned DEF_CLASS_W = 3;
   localparam int unsigned DEF_NUM_CH  = 8;
endpackage

// File: rtl/tcvc_map_table.sv
module tcvc_map_table #(
   parameter int unsigned CLASS_W = 3,
   parameter int unsigned CH_W    = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [CLASS_W-1:0] idx,
   input  logic [CH_W-1:0]    wch,
   output logic [CH_W-1:0]    entry [1<<CLASS_W]
);
   localparam int unsigned N_CLASS = 1 << CLASS_W;

   // class 0 carries no storage: it is wired to channel 0 (R4)
   for (genvar i = 0; i < N_CLASS; i++) begin : g_ent
      if (i == 0) begin : g_lock
         assign entry[i] = '0;
      end else begin : g_reg
         logic [CH_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= '0;
            else if (we && idx == CLASS_W'(i))
               q <= wch;
         end
         assign entry[i] = q;
      end
   end
endmodule

// File: rtl/tcvc_chan_enable.sv
module tcvc_chan_enable #(
   parameter int unsigned NUM_CH = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [NUM_CH-1:0] wdata,
   output logic [NUM_CH-1:0] mask
);
   for (genvar i = 0; i < NUM_CH; i++) begin : g_bit
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= 1'b0;
         else if (we)
            q <= wdata[i];
      end
      if (i == 0) begin : g_pin
         assign mask[i] = q | 1'b1;
      end else begin : g_free
         assign mask[i] = q;
      end
   end
endmodule

// File: rtl/tcvc_lookup.sv
module tcvc_lookup #(
   parameter int unsigned CLASS_W = 3,
   parameter int unsigned NUM_CH  = 8,
   parameter int unsigned CH_W    = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [CH_W-1:0]    entry [1<<CLASS_W],
   input  logic [NUM_CH-1:0]  mask,
   input  logic               pkt_vld,
   input  logic [CLASS_W-1:0] pkt_tc,
   output logic               out_vld,
   output logic [CH_W-1:0]    out_ch,
   output logic               out_err
);
   logic [CH_W-1:0] sel;
   logic            sel_ok;

   always_comb begin
      sel    = entry[pkt_tc];
      sel_ok = mask[sel];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_vld <= 1'b0;
         out_ch  <= '0;
         out_err <= 1'b0;
      end else begin
         out_vld <= pkt_vld;
         out_ch  <= (pkt_vld && sel_ok) ? sel : '0;
         out_err <= pkt_vld && !sel_ok;
      end
   end
endmodule

// File: rtl/tc_vc_steer.sv
module tc_vc_steer #(
   parameter int unsigned CLASS_W = tcvc_pkg::DEF_CLASS_W,
   parameter int unsigned NUM_CH  = tcvc_pkg::DEF_NUM_CH,
   localparam int unsigned CH_W   = $clog2(NUM_CH)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               map_we,
   input  logic [CLASS_W-1:0] map_idx,
   input  logic [CH_W-1:0]    map_ch,
   input  logic               en_we,
   input  logic [NUM_CH-1:0]  en_wdata,
   input  logic               pkt_vld,
   input  logic [CLASS_W-1:0] pkt_tc,
   output logic               out_vld,
   output logic [CH_W-1:0]    out_ch,
   output logic               out_err
);
   if (CLASS_W < 1 || CLASS_W > 4) begin : g_bad_class
      $error("tc_vc_steer: CLASS_W must be 1..4");
   end
   if (NUM_CH < 2 || (1 << CH_W) != NUM_CH) begin : g_bad_ch
      $error("tc_vc_steer: NUM_CH must be a power of two, at least 2");
   end

   logic [CH_W-1:0]   tbl [1<<CLASS_W];
   logic [NUM_CH-1:0] en_mask;

   tcvc_map_table #(.CLASS_W(CLASS_W), .CH_W(CH_W)) u_tbl (
      .clk(clk), .rst_n(rst_n), .we(map_we), .idx(map_idx), .wch(map_ch),
      .entry(tbl)
   );

   tcvc_chan_enable #(.NUM_CH(NUM_CH)) u_en (
      .clk(clk), .rst_n(rst_n), .we(en_we), .wdata(en_wdata), .mask(en_mask)
   );

   tcvc_lookup #(.CLASS_W(CLASS_W), .NUM_CH(NUM_CH), .CH_W(CH_W)) u_lk (
      .clk(clk), .rst_n(rst_n), .entry(tbl), .mask(en_mask),
      .pkt_vld(pkt_vld), .pkt_tc(pkt_tc),
      .out_vld(out_vld), .out_ch(out_ch), .out_err(out_err)
   );
endmodule

// File: rtl/tcvc_steer_chk.sv
module tcvc_steer_chk #(
   parameter int unsigned CLASS_W = 3,
   parameter int unsigned NUM_CH  = 8,
   parameter int unsigned CH_W    = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic               pkt_vld,
   input logic [CLASS_W-1:0] pkt_tc,
   input logic               out_vld,
   input logic [CH_W-1:0]    out_ch,
   input logic               out_err,
   input logic [NUM_CH-1:0]  en_mask
);
   logic              armed;
   logic [NUM_CH-1:0] en_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed   <= 1'b0;
         en_prev <= '0;
      end else begin
         armed   <= 1'b1;
         en_prev <= en_mask;
      end
   end

   p_vld_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> out_vld == $past(pkt_vld));

   p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !out_vld |-> (out_ch == '0 && !out_err));

   p_class0_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(pkt_vld) && $past(pkt_tc) == '0) |-> (out_ch == '0 && !out_err));

   p_err_to_ch0_r5: assert property (@(posedge clk) disable iff (!rst_n)
      out_err |-> (out_vld && out_ch == '0));

   p_ch_enabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && out_vld) |-> en_prev[out_ch]);

   p_mask_bit0_r6: assert property (@(posedge clk) disable iff (!rst_n)
      en_mask[0]);
endmodule

bind tc_vc_steer tcvc_steer_chk #(.CLASS_W(CLASS_W), .NUM_CH(NUM_CH), .CH_W(CH_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .pkt_vld(pkt_vld), .pkt_tc(pkt_tc),
   .out_vld(out_vld), .out_ch(out_ch), .out_err(out_err), .en_mask(en_mask)
);

// File: tb/sim_tc_vc_steer.sv
`timescale 1ns/1ps
module sim_tc_vc_steer;
   localparam int CW = 3;
   localparam int NC = 8;
   localparam int HW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          map_we = 1'b0;
   logic [CW-1:0] map_idx = '0;
   logic [HW-1:0] map_ch = '0;
   logic          en_we = 1'b0;
   logic [NC-1:0] en_wdata = '0;
   logic          pkt_vld = 1'b0;
   logic [CW-1:0] pkt_tc = '0;
   logic          out_vld;
   logic [HW-1:0] out_ch;
   logic          out_err;

   always #2 clk = ~clk;

   tc_vc_steer u0 (.*);

   typedef struct {
      logic [HW-1:0] ch;
      logic          err;
      string         tag;
   } exp_t;

   exp_t          sb[$];
   logic [HW-1:0] m_tbl [8];
   logic [NC-1:0] m_en;
   int            n_chk = 0;
   int            n_bad = 0;
   bit            done = 0;

   task automatic model_reset();
      for (int i = 0; i < 8; i++) m_tbl[i] = '0;
      m_en = 8'h01;
   endtask

   function automatic exp_t predict(logic [CW-1:0] tc, string tag);
      exp_t e;
      logic [HW-1:0] s;
      s = (tc == 0) ? '0 : m_tbl[tc];
      e.tag = tag;
      if (m_en[s]) begin e.ch = s; e.err = 1'b0; end
      else begin e.ch = '0; e.err = 1'b1; end
      return e;
   endfunction

   task automatic model_write_tbl(logic [CW-1:0] i, logic [HW-1:0] c);
      if (i != 0) m_tbl[i] = c;
   endtask

   task automatic idle();
      @(negedge clk);
      pkt_vld = 0; map_we = 0; en_we = 0;
   endtask

   // cycle with optional lookup, table write and mask write in parallel
   task automatic step(bit lk, logic [CW-1:0] tc, bit tw, logic [CW-1:0] ti,
                       logic [HW-1:0] tch, bit ew, logic [NC-1:0] ed, string tag);
      @(negedge clk);
      pkt_vld = lk; pkt_tc = tc;
      map_we = tw; map_idx = ti; map_ch = tch;
      en_we = ew; en_wdata = ed;
      if (lk) sb.push_back(predict(tc, tag));
      if (tw) model_write_tbl(ti, tch);
      if (ew) m_en = ed | 8'h01;
   endtask

   task automatic look(logic [CW-1:0] tc, string tag);
      step(1, tc, 0, '0, '0, 0, '0, tag);
   endtask

   task automatic wr_tbl(logic [CW-1:0] i, logic [HW-1:0] c);
      step(0, '0, 1, i, c, 0, '0, "");
   endtask

   task automatic wr_en(logic [NC-1:0] d);
      step(0, '0, 0, '0, '0, 1, d, "");
   endtask

   // monitor: compare each result just after the edge that produced it
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (rst_n) begin
            if (out_vld) begin
               if (sb.size() == 0) begin
                  n_chk++; n_bad++;
                  $display("FAIL R2: unexpected out_vld, got ch=%0d err=%0d, expected none", out_ch, out_err);
               end else begin
                  exp_t e;
                  e = sb.pop_front();
                  n_chk++;
                  if (out_ch !== e.ch || out_err !== e.err) begin
                     n_bad++;
                     $display("FAIL %s: got ch=%0d err=%0d, expected ch=%0d err=%0d",
                              e.tag, out_ch, out_err, e.ch, e.err);
                  end
               end
            end else if (out_ch !== '0 || out_err !== 1'b0) begin
               n_chk++; n_bad++;
               $display("FAIL R2: idle outputs ch=%0d err=%0d, expected 0 0", out_ch, out_err);
            end
         end
      end
   end

   initial begin
      #800000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      n_chk++;
      if (out_vld !== 0 || out_ch !== 0 || out_err !== 0) begin
         n_bad++;
         $display("FAIL R1: reset outputs vld=%0d ch=%0d err=%0d, expected 0 0 0", out_vld, out_ch, out_err);
      end
      rst_n = 1;
      // R1: reset table maps everything to channel 0
      for (int c = 0; c < 8; c++) look(CW'(c), "R1");
      idle();
      // R3: program a spread of channels, enable all
      wr_en(8'hFE);
      for (int c = 1; c < 8; c++) wr_tbl(CW'(c), HW'(8 - c));
      for (int c = 7; c >= 0; c--) look(CW'(c), "R3");
      idle();
      // R4: attempt to redirect class 0
      wr_tbl(0, 3'd5);
      look(0, "R4");
      idle();
      look(0, "R4");
      // R5 / R6: clear the whole mask, bit 0 must survive
      wr_en(8'h00);
      look(1, "R5");
      look(0, "R6");
      look(2, "R5");
      wr_tbl(4, 3'd0);
      look(4, "R6");
      idle();
      // partial mask: channels 1 and 3
      wr_en(8'h0A);
      for (int c = 1; c < 8; c++) look(CW'(c), "R5");
      idle();
      // R7: table write and lookup of the same class in one cycle
      step(1, 3'd5, 1, 3'd5, 3'd1, 0, '0, "R7");
      look(5, "R7");
      step(1, 3'd7, 1, 3'd7, 3'd2, 0, '0, "R7");
      look(7, "R7");
      idle();
      // R8: mask write and lookup in one cycle
      step(1, 3'd7, 0, '0, '0, 1, 8'h04, "R8");
      look(7, "R8");
      step(1, 3'd5, 0, '0, '0, 1, 8'h00, "R8");
      look(5, "R8");
      idle();
      // R2: sparse requests with gaps
      wr_en(8'hFF);
      look(3, "R2");
      idle();
      idle();
      look(6, "R2");
      idle();
      repeat (4) @(negedge clk);
      n_chk++;
      if (sb.size() != 0) begin
         n_bad++;
         $display("FAIL R2: %0d results missing, expected 0", sb.size());
      end
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule